// File: doc/BRIEF.md
# Multi-Core Boot Release Controller

This block decides, after every kind of reset, which of six processor cores stay held in reset and which start running. It also gives each released core its start address and drives a boot-active output. A device reset comes from a power-on, warm or system request. The first clock after the hardware reset is also treated as a power-on. A device reset picks a boot mode, and that mode sets the initial hold pattern. After that, software or a host releases the cores that are still held by writing one bits into a boot-complete register.

Each core also has a local reset request. A one-bit local boot mode per core decides what that request does. In immediate mode the core restarts at once. In host mode the core stays held until its boot-complete bit is written again. Boot address registers can be written only while their core is held. A core latches its start address on the clock edge that releases it.

Top module: `core_boot_release`

## Requirements
- R1: The first clock edge after `rstN` deasserts acts as a power-on reset, so the mode is taken from `modePins` at that edge. While `rstN` is low, all cores are held and `bootActive` is high.
- R2: A power-on or warm request samples `modePins` and latches the value into the device status register (address 1, bits [3:0]). A system request alone reuses the latched value and leaves it unchanged.
- R3: With mode 0, a device reset releases all six cores on that edge and sets all boot-complete bits. `bootActive` is low after that edge.
- R4: With mode 1, a device reset holds all six cores and clears all boot-complete bits.
- R5: With modes 2 to 15, a device reset releases core 0 and sets its boot-complete bit. It holds cores 1 to 5 and clears their bits.
- R6: `bootActive` is high exactly while at least one core is held.
- R7: Writing to the boot-complete register (address 0) sets each bit that is written as 1. A held core whose bit is written releases on that edge. Bits written as 0 have no effect.
- R8: A device reset loads every boot address register with 0x0080_0000. The exception is core 0, which gets 0x0010_0000 when the mode is 2 to 15. A core released by the device reset starts at that same value.
- R9: The boot address register of core i (address 4+i) accepts a write only while core i is held. Writes at any other time are ignored, and the register reads back its old value.
- R10: `startAddr` of a core is loaded from its boot address register on the edge that releases the core. It does not change while the core keeps running.
- R11: The local mode register is at address 2, with bit i for core i: 0 means immediate and 1 means host. A device reset sets all bits to 0. A local request on a core in immediate mode holds that core for exactly one cycle and then releases it with its bit set.
- R12: A local request on a core in host mode holds the core and clears its boot-complete bit until a 1 is written to that bit.
- R13: A device reset in the same cycle as a local request or a register write takes priority, and the local request or write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset, asynchronous |
| modePins | input | 4 | Boot mode pins |
| porReq | input | 1 | Power-on reset request, one-cycle pulse |
| warmReq | input | 1 | Warm reset request, one-cycle pulse |
| sysReq | input | 1 | System reset request, one-cycle pulse |
| localReq | input | 6 | Per-core local reset requests |
| regWe | input | 1 | Register write enable |
| regAddr | input | 4 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from `regAddr` |
| coreHold | output | 6 | Per-core reset hold, 1 = held |
| startAddr | output | 192 | Per-core start addresses, core i in bits [32i+31:32i] |
| bootActive | output | 1 | High while any core is held |

## Verification
The hardest state to reach from the ports is a collision. Examples are a local request in the same cycle as a device request, or a system request that must reuse a mode latched by an earlier power-on while the pins now show something else. The stimulus sets up these cases on purpose: it changes `modePins` between device requests and pulses a local request together with a system request. A second case is a host-mode core that was already running, then held again, given a new address and released. A behavioural model in the bench tracks every core and register and is compared on every clock, so a wrong release edge or a captured address that goes stale shows up in the first cycle it occurs.

// File: rtl/boot_rel_pkg.sv
package boot_rel_pkg;
  parameter int CORES  = 6;
  parameter int MODE_W = 4;

  localparam int REG_DONE  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_LMODE = 2;
  localparam int REG_ADDR0 = 4;

  typedef struct packed {
    logic             devReset;
    logic             lowBoot0;
    logic [CORES-1:0] rel;
    logic [CORES-1:0] addrWr;
  } bootStrobe_t;
endpackage

// File: rtl/boot_rel_ctrl.sv
module boot_rel_ctrl
  import boot_rel_pkg::*;
#(
  parameter int RAW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modePins,
  input  logic              porReq,
  input  logic              warmReq,
  input  logic              sysReq,
  input  logic [CORES-1:0]  localReq,
  input  logic              regWe,
  input  logic [RAW-1:0]    regAddr,
  input  logic [CORES-1:0]  regWbits,
  output logic [CORES-1:0]  coreHold,
  output logic [CORES-1:0]  complete,
  output logic [CORES-1:0]  localMode,
  output logic [MODE_W-1:0] devMode,
  output logic [MODE_W-1:0] modeSel,
  output logic              devRst,
  output bootStrobe_t       strb
);
  logic             porPend;
  logic             sysOnly;
  logic             wrDone;
  logic             wrLmode;
  logic [CORES-1:0] pend;
  logic [CORES-1:0] setBit;
  logic [CORES-1:0] relNow;
  logic [CORES-1:0] addrWr;

  always_comb begin
    devRst  = porReq | warmReq | sysReq | porPend;
    sysOnly = sysReq & ~porReq & ~warmReq & ~porPend;
    modeSel = sysOnly ? devMode : modePins;
    wrDone  = regWe && (regAddr == RAW'(REG_DONE));
    wrLmode = regWe && (regAddr == RAW'(REG_LMODE));
    for (int i = 0; i < CORES; i++) begin
      setBit[i] = wrDone & regWbits[i];
      addrWr[i] = regWe && !devRst && coreHold[i] &&
                  (regAddr == RAW'(REG_ADDR0 + i));
      if (devRst)
        relNow[i] = (modeSel == '0) || (i == 0 && modeSel != MODE_W'(1));
      else
        relNow[i] = !localReq[i] && coreHold[i] && (pend[i] || setBit[i]);
    end
    strb.devReset = devRst;
    strb.lowBoot0 = modeSel >= MODE_W'(2);
    strb.rel      = relNow;
    strb.addrWr   = addrWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porPend   <= 1'b1;
      coreHold  <= '1;
      complete  <= '0;
      pend      <= '0;
      localMode <= '0;
      devMode   <= '0;
    end else begin
      porPend <= 1'b0;
      if (devRst) begin
        devMode   <= modeSel;
        localMode <= '0;
        pend      <= '0;
        coreHold  <= ~relNow;
        complete  <= relNow;
      end else begin
        if (wrLmode) localMode <= regWbits;
        for (int i = 0; i < CORES; i++) begin
          if (localReq[i]) begin
            coreHold[i] <= 1'b1;
            if (localMode[i]) begin
              complete[i] <= 1'b0;
              pend[i]     <= 1'b0;
            end else begin
              pend[i] <= 1'b1;
            end
          end else if (relNow[i]) begin
            coreHold[i] <= 1'b0;
            complete[i] <= 1'b1;
            pend[i]     <= 1'b0;
          end else if (setBit[i]) begin
            complete[i] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/boot_rel_data.sv
module boot_rel_data
  import boot_rel_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          RAW      = 4,
  parameter logic [AW-1:0] DEF_ADDR = 32'h0080_0000,
  parameter logic [AW-1:0] ALT_ADDR = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  bootStrobe_t       strb,
  input  logic [AW-1:0]     regWdata,
  input  logic [RAW-1:0]    regAddr,
  input  logic [CORES-1:0]  complete,
  input  logic [CORES-1:0]  localMode,
  input  logic [MODE_W-1:0] devMode,
  output logic [AW-1:0]     regRdata,
  output logic [CORES*AW-1:0] startFlat
);
  logic [AW-1:0] addrReg  [CORES];
  logic [AW-1:0] startReg [CORES];
  logic [AW-1:0] resetVal [CORES];

  for (genvar g = 0; g < CORES; g++) begin : g_core
    if (g == 0) begin : g_first
      assign resetVal[g] = strb.lowBoot0 ? ALT_ADDR : DEF_ADDR;
    end else begin : g_other
      assign resetVal[g] = DEF_ADDR;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrReg[g]  <= DEF_ADDR;
        startReg[g] <= DEF_ADDR;
      end else if (strb.devReset) begin
        addrReg[g] <= resetVal[g];
        if (strb.rel[g]) startReg[g] <= resetVal[g];
      end else begin
        if (strb.addrWr[g]) addrReg[g] <= regWdata;
        if (strb.rel[g]) startReg[g] <= addrReg[g];
      end
    end

    assign startFlat[g*AW +: AW] = startReg[g];
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == RAW'(REG_DONE)) begin
      regRdata[CORES-1:0] = complete;
    end else if (regAddr == RAW'(REG_STAT)) begin
      regRdata[MODE_W-1:0] = devMode;
    end else if (regAddr == RAW'(REG_LMODE)) begin
      regRdata[CORES-1:0] = localMode;
    end else begin
      for (int i = 0; i < CORES; i++)
        if (regAddr == RAW'(REG_ADDR0 + i)) regRdata = addrReg[i];
    end
  end
endmodule

// File: rtl/core_boot_release.sv
module core_boot_release
  import boot_rel_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            RAW      = 4,
  parameter logic [AW-1:0] DEF_ADDR = 32'h0080_0000,
  parameter logic [AW-1:0] ALT_ADDR = 32'h0010_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   modePins,
  input  logic                porReq,
  input  logic                warmReq,
  input  logic                sysReq,
  input  logic [CORES-1:0]    localReq,
  input  logic                regWe,
  input  logic [RAW-1:0]      regAddr,
  input  logic [AW-1:0]       regWdata,
  output logic [AW-1:0]       regRdata,
  output logic [CORES-1:0]    coreHold,
  output logic [CORES*AW-1:0] startAddr,
  output logic                bootActive
);
  bootStrobe_t       strb;
  logic [CORES-1:0]  complete;
  logic [CORES-1:0]  localMode;
  logic [MODE_W-1:0] devMode;
  logic [MODE_W-1:0] modeSel;
  logic              devRst;

  boot_rel_ctrl #(.RAW(RAW)) u_ctrl (
    .clk(clk), .rstN(rstN), .modePins(modePins),
    .porReq(porReq), .warmReq(warmReq), .sysReq(sysReq),
    .localReq(localReq), .regWe(regWe), .regAddr(regAddr),
    .regWbits(regWdata[CORES-1:0]),
    .coreHold(coreHold), .complete(complete), .localMode(localMode),
    .devMode(devMode), .modeSel(modeSel), .devRst(devRst), .strb(strb)
  );

  boot_rel_data #(.AW(AW), .RAW(RAW), .DEF_ADDR(DEF_ADDR), .ALT_ADDR(ALT_ADDR)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .regAddr(regAddr), .complete(complete), .localMode(localMode),
    .devMode(devMode), .regRdata(regRdata), .startFlat(startAddr)
  );

  assign bootActive = |coreHold;
endmodule

// File: rtl/boot_rel_chk.sv
module boot_rel_chk
  import boot_rel_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            RAW      = 4,
  parameter logic [AW-1:0] DEF_ADDR = 32'h0080_0000,
  parameter logic [AW-1:0] ALT_ADDR = 32'h0010_0000
) (
  input logic                clk,
  input logic                rstN,
  input logic                devRst,
  input logic [MODE_W-1:0]   modeSel,
  input logic [MODE_W-1:0]   modePins,
  input logic [MODE_W-1:0]   devMode,
  input logic                porReq,
  input logic                regWe,
  input logic [RAW-1:0]      regAddr,
  input logic [AW-1:0]       regWdata,
  input logic [CORES-1:0]    localReq,
  input logic [CORES-1:0]    localMode,
  input logic [CORES-1:0]    coreHold,
  input logic [CORES-1:0]    complete,
  input logic                bootActive,
  input logic [CORES*AW-1:0] startAddr
);
  p_mode0_r3: assert property (@(posedge clk) disable iff (!rstN)
    devRst && modeSel == '0 |=> coreHold == '0 && !bootActive);

  p_mode1_r4: assert property (@(posedge clk) disable iff (!rstN)
    devRst && modeSel == MODE_W'(1) |=> &coreHold && complete == '0);

  p_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    porReq |=> devMode == $past(modePins));

  p_idle_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !bootActive |-> &complete);

  p_core0_alt_r8: assert property (@(posedge clk) disable iff (!rstN)
    devRst && modeSel >= MODE_W'(2) |=> startAddr[AW-1:0] == ALT_ADDR && !coreHold[0]);

  for (genvar g = 0; g < CORES; g++) begin : g_core
    p_w1s_release_r7: assert property (@(posedge clk) disable iff (!rstN)
      coreHold[g] && !devRst && !localReq[g] && regWe &&
      regAddr == RAW'(REG_DONE) && regWdata[g] |=> !coreHold[g] && complete[g]);

    p_start_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
      !coreHold[g] && !devRst && !localReq[g] |=> $stable(startAddr[g*AW +: AW]));

    p_local_host_r12: assert property (@(posedge clk) disable iff (!rstN)
      localReq[g] && localMode[g] && !devRst |=> coreHold[g] && !complete[g]);

    p_local_imm_r11: assert property (@(posedge clk) disable iff (!rstN)
      localReq[g] && !localMode[g] && !devRst |=> coreHold[g]);
  end
endmodule

bind core_boot_release boot_rel_chk #(
  .AW(AW), .RAW(RAW), .DEF_ADDR(DEF_ADDR), .ALT_ADDR(ALT_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .devRst(devRst), .modeSel(modeSel),
  .modePins(modePins), .devMode(devMode), .porReq(porReq),
  .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .localReq(localReq), .localMode(localMode), .coreHold(coreHold),
  .complete(complete), .bootActive(bootActive), .startAddr(startAddr)
);

// File: tb/core_boot_release_tb.sv
module core_boot_release_tb;
  localparam logic [31:0] DEF = 32'h0080_0000;
  localparam logic [31:0] ALT = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  modePins = 4'd1;
  logic        porReq = 0, warmReq = 0, sysReq = 0;
  logic [5:0]  localReq = '0;
  logic        regWe = 0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [5:0]  coreHold;
  logic [191:0] startAddr;
  logic        bootActive;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  core_boot_release u_dut (
    .clk(clk), .rstN(rstN), .modePins(modePins), .porReq(porReq),
    .warmReq(warmReq), .sysReq(sysReq), .localReq(localReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .coreHold(coreHold), .startAddr(startAddr),
    .bootActive(bootActive)
  );

  // behavioural reference
  logic        mPor;
  logic [5:0]  mHold, mDone, mPend, mLm;
  logic [3:0]  mMode;
  logic [31:0] mAddr [6];
  logic [31:0] mStart [6];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPor = 1; mHold = '1; mDone = '0; mPend = '0; mLm = '0; mMode = '0;
      for (int i = 0; i < 6; i++) begin mAddr[i] = DEF; mStart[i] = DEF; end
    end else begin
      automatic bit dev = porReq | warmReq | sysReq | mPor;
      automatic logic [3:0] ms = (sysReq && !porReq && !warmReq && !mPor) ? mMode : modePins;
      automatic logic [5:0] oldHold = mHold;
      if (dev) begin
        mMode = ms; mLm = '0; mPend = '0;
        for (int i = 0; i < 6; i++) begin
          automatic logic [31:0] d = (i == 0 && ms >= 2) ? ALT : DEF;
          automatic bit go = (ms == 0) || (i == 0 && ms != 1);
          mAddr[i] = d; mHold[i] = !go; mDone[i] = go;
          if (go) mStart[i] = d;
        end
      end else begin
        for (int i = 0; i < 6; i++) begin
          automatic bit w1 = regWe && regAddr == 0 && regWdata[i];
          if (regWe && regAddr == 4 + i && oldHold[i]) mAddr[i] = regWdata;
          if (localReq[i]) begin
            mHold[i] = 1;
            if (mLm[i]) begin mDone[i] = 0; mPend[i] = 0; end
            else mPend[i] = 1;
          end else if (oldHold[i] && (mPend[i] || w1)) begin
            mHold[i] = 0; mDone[i] = 1; mPend[i] = 0; mStart[i] = mAddr[i];
          end else if (w1) mDone[i] = 1;
        end
        if (regWe && regAddr == 2) mLm = regWdata[5:0];
      end
      mPor = 0;
    end
  end

  function automatic logic [31:0] mRead(input logic [3:0] a);
    case (a)
      4'd0: return {26'd0, mDone};
      4'd1: return {28'd0, mMode};
      4'd2: return {26'd0, mLm};
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return mAddr[a - 4];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (rstN) begin
      check("R3 R4 R5 R11 R12 coreHold", {186'd0, coreHold}, {186'd0, mHold});
      check("R6 bootActive", {191'd0, bootActive}, {191'd0, |mHold});
      for (int i = 0; i < 6; i++)
        check("R8 R10 startAddr", {160'd0, startAddr[i*32 +: 32]}, {160'd0, mStart[i]});
      check("R2 R7 R9 R11 regRdata", {160'd0, regRdata}, {160'd0, mRead(regAddr)});
    end else begin
      check("R1 hold in reset", {186'd0, coreHold}, {186'd0, 6'h3F});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic nxt(); @(posedge clk); #2; endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      nxt(); regAddr = 4'(k % 10);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    nxt(); regWe = 1; regAddr = a; regWdata = d;
    nxt(); regWe = 0; regWdata = '0;
  endtask

  task automatic devReq(input bit p, input bit w, input bit s, input logic [5:0] loc);
    nxt(); porReq = p; warmReq = w; sysReq = s; localReq = loc;
    nxt(); porReq = 0; warmReq = 0; sysReq = 0; localReq = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    idle(3);
    // R1: first edge behaves as power-on with pins = 1 (host)
    check("R1 R4 all held", {186'd0, coreHold}, {186'd0, 6'h3F});
    rd(1, v); check("R1 R2 status mode", {160'd0, v}, {160'd0, 32'd1});
    // R9: write while held is accepted
    wr(4'd6, 32'h0012_3400);
    rd(6, v); check("R9 write while held", {160'd0, v}, {160'd0, 32'h0012_3400});
    // R7: write-1 releases core 2
    wr(4'd0, 32'h0000_0004);
    check("R7 core2 released", {186'd0, coreHold}, {186'd0, 6'h3B});
    check("R10 core2 start", {160'd0, startAddr[64 +: 32]}, {160'd0, 32'h0012_3400});
    // R9: write while running ignored
    wr(4'd6, 32'h0ABC_0000);
    rd(6, v); check("R9 write while running ignored", {160'd0, v}, {160'd0, 32'h0012_3400});
    // R7: zero bits do nothing
    wr(4'd0, 32'h0000_0000);
    check("R7 zero write no effect", {186'd0, coreHold}, {186'd0, 6'h3B});
    wr(4'd0, 32'h0000_003F);
    check("R6 all released", {191'd0, bootActive}, 192'd0);
    idle(4);
    // R3: warm reset with mode 0
    modePins = 4'd0;
    devReq(0, 1, 0, '0);
    check("R3 mode0 all run", {186'd0, coreHold}, 192'd0);
    check("R8 core0 default", {160'd0, startAddr[31:0]}, {160'd0, DEF});
    idle(3);
    // R5/R8: power-on with mode 5
    modePins = 4'd5;
    devReq(1, 0, 0, '0);
    check("R5 mode5 hold", {186'd0, coreHold}, {186'd0, 6'h3E});
    check("R8 core0 alt start", {160'd0, startAddr[31:0]}, {160'd0, ALT});
    rd(1, v); check("R2 latched 5", {160'd0, v}, {160'd0, 32'd5});
    idle(3);
    // R2: system reset reuses latched mode even though pins say 1
    modePins = 4'd1;
    devReq(0, 0, 1, '0);
    check("R2 sys reuses latched", {186'd0, coreHold}, {186'd0, 6'h3E});
    rd(1, v); check("R2 status unchanged", {160'd0, v}, {160'd0, 32'd5});
    // R12: core3 host local mode
    wr(4'd2, 32'h0000_0008);
    wr(4'd0, 32'h0000_003E);
    idle(2);
    devReq(0, 0, 0, 6'h08);
    check("R12 core3 held", {191'd0, coreHold[3]}, {191'd0, 1'b1});
    rd(0, v); check("R12 done bit cleared", {160'd0, v}, {160'd0, 32'h37});
    idle(3);
    check("R12 still held", {191'd0, coreHold[3]}, {191'd0, 1'b1});
    wr(4'd7, 32'h0055_0000);
    wr(4'd0, 32'h0000_0008);
    check("R10 core3 new start", {160'd0, startAddr[96 +: 32]}, {160'd0, 32'h0055_0000});
    // R11: immediate local on core1
    devReq(0, 0, 0, 6'h02);
    check("R11 core1 held one cycle", {191'd0, coreHold[1]}, {191'd0, 1'b1});
    nxt();
    check("R11 core1 released", {191'd0, coreHold[1]}, 192'd0);
    idle(2);
    // R13: system request with local request; device reset wins (mode 5)
    devReq(0, 0, 1, 6'h01);
    check("R13 device reset wins", {186'd0, coreHold}, {186'd0, 6'h3E});
    rd(2, v); check("R13 local modes cleared", {160'd0, v}, 192'd0);
    // R11: local immediate on a held core releases it
    devReq(0, 0, 0, 6'h10);
    nxt();
    check("R11 held core restarted", {191'd0, coreHold[4]}, 192'd0);
    idle(6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule